// File: doc/BRIEF.md
# Three-Path Arithmetic Logic Unit with Condition Flags

This block is a purely combinational arithmetic logic unit for a 32-bit datapath. Three independent engines work on the same pair of operands at once. The first is an adder that can also subtract. The second is a bit-sliced logic unit. The third is a barrel shifter that can shift left or right. A two-level output multiplexer then forwards one engine's answer as the result. The surrounding pipeline supplies the operands and control bits in the same cycle and takes the result and the four condition flags before its next register stage.

The carry and overflow flags always come from the adder, whichever engine is selected. The zero and negative flags are computed on the final multiplexed result, so a comparison (subtract, then read the flags) and a plain logic or shift operation report zero and sign in the same way. The shift distance is taken from the low five bits of the second operand.

Top module: `alu3_core`

## Requirements
- R1: With `pick_logic`=0 and `sub`=0, `result` equals `a + b` modulo 2^32, and `flag_c` is the carry out of bit 31.
- R2: With `pick_logic`=0 and `sub`=1, `result` equals `a - b` modulo 2^32, and `flag_c` is 1 exactly when `a >= b` as unsigned numbers (no borrow).
- R3: With `pick_logic`=0, `flag_v` is 1 exactly when the signed two's-complement sum (or difference) does not fit in 32 bits.
- R4: With `pick_logic`=1 and `pick_shift`=0, each result bit is a function of `a[i]` and `b[i]` alone, chosen by `bool_fn`: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR.
- R5: With `pick_logic`=1, `pick_shift`=1 and `shift_right`=0, `result` is `a` shifted left by `b[4:0]` places with zeros filling from the bottom. Bits 31:5 of `b` have no effect.
- R6: With `shift_right`=1 and `shift_arith`=0, the shifter moves `a` right by `b[4:0]` places with zero fill.
- R7: With `shift_right`=1 and `shift_arith`=1, the shifter moves `a` right by `b[4:0]` places and copies `a[31]` into the vacated top bits.
- R8: `pick_logic` selects between the adder (0) and the logic/shift pair (1). Within that pair, `pick_shift` selects the logic unit (0) or the shifter (1).
- R9: `flag_z` is 1 exactly when the final `result` is all zeros, whichever engine produced it.
- R10: `flag_n` equals bit 31 of the final `result`, whichever engine produced it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand; the value that is shifted |
| b | input | 32 | Second operand; low 5 bits give the shift distance |
| sub | input | 1 | 1 = subtract b from a, 0 = add |
| bool_fn | input | 2 | Logic function code: 00 AND, 01 OR, 10 XOR, 11 NOR |
| shift_right | input | 1 | 1 = shift toward bit 0, 0 = shift toward bit 31 |
| shift_arith | input | 1 | With a right shift, 1 = sign fill, 0 = zero fill |
| pick_shift | input | 1 | Within the logic/shift pair: 1 = shifter, 0 = logic unit |
| pick_logic | input | 1 | 1 = logic/shift pair, 0 = adder |
| result | output | 32 | Selected result |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 31 |
| flag_c | output | 1 | Adder carry out |
| flag_v | output | 1 | Adder signed overflow |

## Verification
Two things are always produced in the same evaluation: the adder's carry and overflow, and the zero and sign flags of whichever engine the multiplexer selects. The bench drives operand pairs that give opposite answers on the two paths. One example is a shift or XOR that yields zero while the adder sum is nonzero. Another is a subtraction of equal operands that yields zero with a carry, set beside a logic result that is negative. For each vector, a model computed from the requirements predicts every flag. The zero and sign flags are always compared against the selected result. Carry and overflow are compared only when the adder is selected.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

   // Logic unit function codes (R4)
   typedef enum logic [1:0] {
      BOOL_AND = 2'b00,
      BOOL_OR  = 2'b01,
      BOOL_XOR = 2'b10,
      BOOL_NOR = 2'b11
   } bool_op_e;

   // Adder implementation variants
   typedef enum int {
      ADD_RIPPLE   = 0,
      ADD_OPERATOR = 1
   } add_arch_e;

endpackage

// File: rtl/alu3_addsub.sv
module alu3_addsub
   import alu3_pkg::*;
#(
   parameter int        WIDTH = 32,
   parameter add_arch_e ARCH  = ADD_RIPPLE
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             do_sub,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = op_b ^ {WIDTH{do_sub}};

   generate
      if (ARCH == ADD_RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = do_sub;
         for (genvar i = 0; i < WIDTH; i++) begin : g_fa
            logic p;
            assign p        = op_a[i] ^ b_eff[i];
            assign sum[i]   = p ^ cy[i];
            assign cy[i+1]  = (op_a[i] & b_eff[i]) | (p & cy[i]);
         end
         assign carry_out = cy[WIDTH];
         assign ovf       = cy[WIDTH] ^ cy[WIDTH-1];
      end else begin : g_operator
         logic [WIDTH:0] wide;
         assign wide      = {1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub};
         assign sum       = wide[WIDTH-1:0];
         assign carry_out = wide[WIDTH];
         assign ovf       = (op_a[MSB] == b_eff[MSB]) && (sum[MSB] != op_a[MSB]);
      end
   endgenerate

   always_comb begin
      // R2
      eq_sub_chk: assert (!(do_sub && (op_a == op_b)) || (sum == '0 && carry_out));
      // R1
      add_ref_chk: assert (do_sub || ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b})));
   end

endmodule

// File: rtl/alu3_bool.sv
module alu3_bool_slice
   import alu3_pkg::*;
(
   input  logic     ai,
   input  logic     bi,
   input  bool_op_e op,
   output logic     qi
);
   logic t_and, t_or, t_xor, t_nor;
   assign t_and = ai & bi;
   assign t_or  = ai | bi;
   assign t_xor = ai ^ bi;
   assign t_nor = ~t_or;

   always_comb begin
      unique case (op)
         BOOL_AND: qi = t_and;
         BOOL_OR:  qi = t_or;
         BOOL_XOR: qi = t_xor;
         BOOL_NOR: qi = t_nor;
         default:  qi = t_and;
      endcase
   end
endmodule

module alu3_bool
   import alu3_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  bool_op_e         op,
   output logic [WIDTH-1:0] q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      alu3_bool_slice u_slice (
         .ai (op_a[i]),
         .bi (op_b[i]),
         .op (op),
         .qi (q[i])
      );
   end

   always_comb begin
      // R4
      xor_form_chk: assert (op != BOOL_XOR || q == ((op_a | op_b) & ~(op_a & op_b)));
      // R4
      nor_and_chk: assert (op != BOOL_NOR || (q & op_a) == '0);
   end
endmodule

// File: rtl/alu3_shift.sv
module alu3_shift #(
   parameter int WIDTH   = 32,
   parameter int SHAMT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0]   din,
   input  logic [SHAMT_W-1:0] amount,
   input  logic               to_right,
   input  logic               arith,
   output logic [WIDTH-1:0]   dout
);
   localparam int MSB = WIDTH - 1;

   logic             fill;
   logic [WIDTH-1:0] entry;
   logic [WIDTH-1:0] stage [SHAMT_W+1];

   assign fill = to_right & arith & din[MSB];

   // Right shifts reuse the left barrel on the bit-reversed word.
   for (genvar i = 0; i < WIDTH; i++) begin : g_rev_in
      assign entry[i] = to_right ? din[MSB-i] : din[i];
   end

   assign stage[0] = entry;

   for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
      localparam int DIST = 1 << s;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i >= DIST) begin : g_take
            assign stage[s+1][i] = amount[s] ? stage[s][i-DIST] : stage[s][i];
         end else begin : g_fill
            assign stage[s+1][i] = amount[s] ? fill : stage[s][i];
         end
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_rev_out
      assign dout[i] = to_right ? stage[SHAMT_W][MSB-i] : stage[SHAMT_W][i];
   end

   logic [WIDTH-1:0] low_mask;
   assign low_mask = (WIDTH'(1) << amount) - WIDTH'(1);

   always_comb begin
      // R5
      shamt_zero_chk: assert (amount != '0 || dout == din);
      // R5
      left_fill_chk: assert (to_right || (dout & low_mask) == '0);
   end
endmodule

// File: rtl/alu3_flags.sv
module alu3_flags #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] res,
   output logic             is_zero,
   output logic             is_neg
);
   assign is_zero = ~|res;
   assign is_neg  = res[WIDTH-1];
endmodule

// File: rtl/alu3_core.sv
module alu3_core
   import alu3_pkg::*;
#(
   parameter int        WIDTH    = 32,
   parameter add_arch_e ADD_ARCH = ADD_RIPPLE
) (
   input  logic [31:0] a,
   input  logic [31:0] b,
   input  logic        sub,
   input  logic [1:0]  bool_fn,
   input  logic        shift_right,
   input  logic        shift_arith,
   input  logic        pick_shift,
   input  logic        pick_logic,
   output logic [31:0] result,
   output logic        flag_z,
   output logic        flag_n,
   output logic        flag_c,
   output logic        flag_v
);
   localparam int SHAMT_W = $clog2(WIDTH);

   if (WIDTH != 32) begin : g_bad_width
      $error("alu3_core: WIDTH must match the 32-bit port list");
   end
   if ((1 << SHAMT_W) != WIDTH) begin : g_bad_pow2
      $error("alu3_core: WIDTH must be a power of two");
   end

   logic [WIDTH-1:0] sum_w, bool_w, shift_w, pair_w;
   logic             c_w, v_w;

   alu3_addsub #(.WIDTH(WIDTH), .ARCH(ADD_ARCH)) u_addsub (
      .op_a      (a),
      .op_b      (b),
      .do_sub    (sub),
      .sum       (sum_w),
      .carry_out (c_w),
      .ovf       (v_w)
   );

   alu3_bool #(.WIDTH(WIDTH)) u_bool (
      .op_a (a),
      .op_b (b),
      .op   (bool_op_e'(bool_fn)),
      .q    (bool_w)
   );

   alu3_shift #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
      .din      (a),
      .amount   (b[SHAMT_W-1:0]),
      .to_right (shift_right),
      .arith    (shift_arith),
      .dout     (shift_w)
   );

   assign pair_w = pick_shift ? shift_w : bool_w;
   assign result = pick_logic ? pair_w  : sum_w;
   assign flag_c = c_w;
   assign flag_v = v_w;

   alu3_flags #(.WIDTH(WIDTH)) u_flags (
      .res     (result),
      .is_zero (flag_z),
      .is_neg  (flag_n)
   );

   always_comb begin
      // R9
      zero_not_neg_chk: assert (!flag_z || !flag_n);
      // R8
      arith_sel_chk: assert (pick_logic || !(flag_z && !sub && (a == '0) && (b != '0)));
   end

endmodule

// File: tb/alu3_core_tb.sv
module alu3_core_tb;
   logic        clk = 0;
   logic        rst = 1;
   logic [31:0] a = '0, b = '0;
   logic        sub = 0, shift_right = 0, shift_arith = 0, pick_shift = 0, pick_logic = 0;
   logic [1:0]  bool_fn = '0;
   logic [31:0] result;
   logic        flag_z, flag_n, flag_c, flag_v;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   alu3_core u_dut (
      .a(a), .b(b), .sub(sub), .bool_fn(bool_fn),
      .shift_right(shift_right), .shift_arith(shift_arith),
      .pick_shift(pick_shift), .pick_logic(pick_logic),
      .result(result), .flag_z(flag_z), .flag_n(flag_n),
      .flag_c(flag_c), .flag_v(flag_v)
   );

   typedef struct {
      logic [31:0] res;
      logic        z, n, c, v, arith;
      string       tag;
   } exp_t;

   exp_t sb[$];

   function automatic exp_t model(logic [31:0] x, logic [31:0] y, logic s, logic [1:0] f,
                                  logic r, logic ar, logic ps, logic pl, string tag);
      exp_t e;
      logic [32:0] w;
      logic [4:0]  sh;
      sh = y[4:0];
      w  = s ? ({1'b0, x} + {1'b0, ~y} + 33'd1) : ({1'b0, x} + {1'b0, y});
      e.c = w[32];
      e.v = s ? (x[31] != y[31] && w[31] != x[31]) : (x[31] == y[31] && w[31] != x[31]);
      e.arith = !pl;
      if (!pl) e.res = w[31:0];
      else if (!ps) begin
         case (f)
            2'b00: e.res = x & y;
            2'b01: e.res = x | y;
            2'b10: e.res = x ^ y;
            default: e.res = ~(x | y);
         endcase
      end else if (!r) e.res = x << sh;
      else if (!ar)    e.res = x >> sh;
      else             e.res = $unsigned($signed(x) >>> sh);
      e.z = (e.res == 0);
      e.n = e.res[31];
      e.tag = tag;
      return e;
   endfunction

   task automatic drive(logic [31:0] x, logic [31:0] y, logic s, logic [1:0] f,
                        logic r, logic ar, logic ps, logic pl, string tag);
      @(negedge clk);
      a = x; b = y; sub = s; bool_fn = f; shift_right = r; shift_arith = ar;
      pick_shift = ps; pick_logic = pl;
      sb.push_back(model(x, y, s, f, r, ar, ps, pl, tag));
   endtask

   task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Monitor: inputs change at negedge, compare at the following posedge.
   initial begin
      forever begin
         @(posedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.tag, "result", result, e.res);
            cmp({e.tag, " R9"}, "flag_z", 32'(flag_z), 32'(e.z));
            cmp({e.tag, " R10"}, "flag_n", 32'(flag_n), 32'(e.n));
            if (e.arith) begin
               cmp({e.tag, " R1/R2"}, "flag_c", 32'(flag_c), 32'(e.c));
               cmp({e.tag, " R3"}, "flag_v", 32'(flag_v), 32'(e.v));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // Reset state: all inputs zero gives a zero sum, Z set.
      repeat (3) @(posedge clk);
      #1;
      cmp("reset R1", "result", result, 32'h0);
      cmp("reset R9", "flag_z", 32'(flag_z), 32'h1);
      rst = 0;

      // R1 add
      drive(32'h0000_0005, 32'h0000_0003, 0, 2'b00, 0, 0, 0, 0, "R1 add small");
      drive(32'hFFFF_FFFF, 32'h0000_0001, 0, 2'b00, 0, 0, 0, 0, "R1 add wrap");
      // R3 overflow
      drive(32'h7FFF_FFFF, 32'h0000_0001, 0, 2'b00, 0, 0, 0, 0, "R3 add ovf");
      drive(32'h8000_0000, 32'h8000_0000, 0, 2'b00, 0, 0, 0, 0, "R3 add neg ovf");
      // R2 subtract
      drive(32'h1234_5678, 32'h1234_5678, 1, 2'b00, 0, 0, 0, 0, "R2 sub equal");
      drive(32'h0000_0000, 32'h0000_0001, 1, 2'b00, 0, 0, 0, 0, "R2 sub borrow");
      drive(32'h8000_0000, 32'h0000_0001, 1, 2'b00, 0, 0, 0, 0, "R3 sub ovf");
      // R4 logic functions
      drive(32'hAE, 32'h0F, 0, 2'b00, 0, 0, 0, 1, "R4 and");
      drive(32'hAE, 32'h0F, 0, 2'b01, 0, 0, 0, 1, "R4 or");
      drive(32'hAE, 32'h0F, 0, 2'b10, 0, 0, 0, 1, "R4 xor");
      drive(32'hAE, 32'h0F, 0, 2'b11, 0, 0, 0, 1, "R4 nor");
      drive(32'hCAFE_F00D, 32'hCAFE_F00D, 0, 2'b10, 0, 0, 0, 1, "R9 xor zero");
      // R5 left shift
      drive(32'h14, 32'd1, 0, 2'b00, 0, 0, 1, 1, "R5 shl 1");
      drive(32'h14, 32'h0000_0021, 0, 2'b00, 0, 0, 1, 1, "R5 shl upper b ignored");
      drive(32'h0000_0003, 32'd31, 0, 2'b00, 0, 0, 1, 1, "R5 shl 31");
      drive(32'h8000_0001, 32'd0, 0, 2'b00, 0, 0, 1, 1, "R5 shl 0");
      drive(32'h8000_0000, 32'd1, 1, 2'b00, 0, 0, 1, 1, "R9 shl out zero");
      // R6 logical right
      drive(32'hFFFF_FFEC, 32'd1, 0, 2'b00, 1, 0, 1, 1, "R6 shr 1");
      drive(32'h8000_0000, 32'd31, 0, 2'b00, 1, 0, 1, 1, "R6 shr 31");
      // R7 arithmetic right
      drive(32'hFFFF_FFEC, 32'd1, 0, 2'b00, 1, 1, 1, 1, "R7 sar 1");
      drive(32'h8000_0000, 32'd31, 0, 2'b00, 1, 1, 1, 1, "R7 sar 31");
      drive(32'h4000_0000, 32'd4, 0, 2'b00, 1, 1, 1, 1, "R7 sar positive");
      // R8 select: same operands through each path
      drive(32'hF000_0000, 32'h1000_0000, 0, 2'b01, 0, 0, 0, 0, "R8 sel arith");
      drive(32'hF000_0000, 32'h1000_0000, 0, 2'b01, 0, 0, 0, 1, "R8 sel logic");
      drive(32'hF000_0000, 32'h1000_0000, 0, 2'b01, 0, 0, 1, 1, "R8 sel shift");
      // Mixed vectors covering every mode
      for (int k = 0; k < 200; k++) begin
         logic [31:0] x, y;
         logic [7:0]  m;
         x = $urandom();
         y = $urandom();
         m = 8'($urandom());
         drive(x, y, m[0], m[2:1], m[3], m[4], m[5], m[6], "R8 mixed");
      end

      while (sb.size() > 0) @(posedge clk);
      @(negedge clk);
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule